// File: doc/BRIEF.md
# Variable-Rate Slot Request Pacer

This block sits in the codec side of a fixed-rate serial audio link whose frames arrive at 48 kHz. For one return slot it decides, frame by frame, whether the codec asks the controller for a new sample. A stream with a lower sample rate then crosses the link by having only some frames carry valid data. A fractional phase accumulator spreads the requested frames evenly over time rather than grouping them in bursts. At 44.1 kHz, 441 of every 480 frames are requested, and a skipped frame is always followed by a requested one.

The request flag is active low, matching the request bits in the low part of return slot 1. It is updated only on the frame strobe and is held for exactly that frame. A two-state controller follows the enable as sampled at each strobe.

- `PACE_OFF` is the reset state. In this state the accumulator is held at zero and no request is raised.
- Transition *start*: `PACE_OFF` to `PACE_RUN`, on a strobe with enable high. That strobe already accumulates.
- Transition *stop*: `PACE_RUN` to `PACE_OFF`, on a strobe with enable low. It clears the accumulator and drops the request.
- In every other cycle each state holds.

Top module: `vrate_pacer`

## Requirements
- R1: After reset `req_n` is 1 and the phase accumulator is zero.
- R2: `req_n` changes only in the clock cycle after a cycle with `frame_stb` high. Between strobes it holds its value.
- R3: A strobe with `enable` low drives `req_n` to 1 and resets the accumulator to zero. After re-enabling at 44100, the first frame is therefore not requested and the second is.
- R4: On a strobe with `enable` high, the clamped rate is added to the accumulator. If the sum is 48000 or more, the frame is requested (`req_n` = 0) and 48000 is subtracted. Otherwise `req_n` = 1 and the sum is kept.
- R5: A rate of 48000 or higher is treated as 48000, so every enabled frame is requested.
- R6: A rate of 0 never raises a request.
- R7: At a rate of 44100, every window of 480 consecutive frames contains exactly 441 requested frames, and no two consecutive frames are both unrequested.
- R8: `enable` and `rate` are looked at only in the strobe cycle. Changes between strobes have no effect on `req_n` or on later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle pulse at the start of each link frame |
| rate | input | 16 | Programmed sample rate in Hz |
| enable | input | 1 | Stream enable, sampled on `frame_stb` |
| req_n | output | 1 | Per-frame sample request, 0 = requested |

## Verification
Several directed patterns each isolate one behaviour:
- Full rate and above-full rate show the clamp.
- Zero rate shows the idle case.
- A disable/enable pair shows that the accumulator restarts from zero rather than carrying phase.
- Enable pulses between strobes separate strobe-qualified sampling from level sensitivity.

A long 44.1 kHz run is checked over every sliding 480-frame window, so that even spreading can be told apart from a correct total delivered in bursts. Random rates and enables with random gaps between strobes are compared frame by frame against a bench model of the accumulate-and-wrap rule.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
    typedef enum logic [0:0] {
        PACE_OFF = 1'b0,
        PACE_RUN = 1'b1
    } pace_state_t;
endpackage

// File: rtl/vrp_rate_clamp.sv
module vrp_rate_clamp #(
    parameter int IN_W       = 16,
    parameter int FRAME_RATE = 48000,
    parameter int OUT_W      = 16
) (
    input  logic [IN_W-1:0]  rate_in,
    output logic [OUT_W-1:0] step_out
);
    localparam logic [IN_W:0] LIMIT = (IN_W+1)'(FRAME_RATE);

    // R5: any rate at or above the frame rate requests every frame
    always_comb begin
        if ({1'b0, rate_in} >= LIMIT)
            step_out = OUT_W'(FRAME_RATE);
        else
            step_out = OUT_W'(rate_in);
    end
endmodule

// File: rtl/vrp_phase_acc.sv
module vrp_phase_acc #(
    parameter int FRAME_RATE = 48000,
    parameter int ACC_W      = $clog2(FRAME_RATE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step,
    input  logic             advance,
    input  logic             clear,
    output logic             hit
);
    localparam logic [ACC_W:0] WRAP = (ACC_W+1)'(FRAME_RATE);

    logic [ACC_W-1:0] phase_q;
    logic [ACC_W:0]   sum;

    always_comb begin
        sum = {1'b0, phase_q} + {1'b0, step};
        hit = (sum >= WRAP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (clear)
            phase_q <= '0;
        else if (advance)
            phase_q <= hit ? ACC_W'(sum - WRAP) : ACC_W'(sum);
    end

    // R4: residual phase always stays below one frame-rate unit
    a_r4_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, phase_q} < WRAP);

    // R3: a disable strobe leaves the accumulator at zero
    a_r3_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (phase_q == '0));
endmodule

// File: rtl/vrp_pace_ctrl.sv
module vrp_pace_ctrl
    import vrp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic enable,
    input  logic hit,
    output logic advance,
    output logic clear,
    output logic req_n
);
    pace_state_t state_q, state_d;
    logic        req_n_q, req_n_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PACE_OFF;
            req_n_q <= 1'b1;
        end else begin
            state_q <= state_d;
            req_n_q <= req_n_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PACE_OFF: if (frame_stb && enable)  state_d = PACE_RUN; // start
            PACE_RUN: if (frame_stb && !enable) state_d = PACE_OFF; // stop
            default:  state_d = PACE_OFF;
        endcase
        advance = frame_stb && enable;
        clear   = frame_stb && !enable;
        if (frame_stb)
            req_n_d = enable ? !hit : 1'b1;
        else
            req_n_d = req_n_q;
    end

    assign req_n = req_n_q;

    // R2: the request holds between strobes
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(req_n_q));

    // R3: no request while stopped
    a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PACE_OFF) |-> req_n_q);
endmodule

// File: rtl/vrate_pacer.sv
module vrate_pacer #(
    parameter int RATE_W     = 16,
    parameter int FRAME_RATE = 48000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [RATE_W-1:0] rate,
    input  logic              enable,
    output logic              req_n
);
    localparam int ACC_W = $clog2(FRAME_RATE + 1);

    logic [ACC_W-1:0] step;
    logic             hit, advance, clear;

    vrp_rate_clamp #(.IN_W(RATE_W), .FRAME_RATE(FRAME_RATE), .OUT_W(ACC_W)) clamp_i (
        .rate_in  (rate),
        .step_out (step)
    );

    vrp_phase_acc #(.FRAME_RATE(FRAME_RATE), .ACC_W(ACC_W)) acc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .advance (advance),
        .clear   (clear),
        .hit     (hit)
    );

    vrp_pace_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .enable    (enable),
        .hit       (hit),
        .advance   (advance),
        .clear     (clear),
        .req_n     (req_n)
    );

    // R5: full or excess rate requests the frame
    a_r5_full: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && enable && ({1'b0, rate} >= (RATE_W+1)'(FRAME_RATE))) |=> !req_n);

    // R6: zero rate never requests
    a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && (rate == '0)) |=> req_n);
endmodule

// File: tb/vrate_pacer_tb_top.sv
`timescale 1ns/1ps
module vrate_pacer_tb_top;
    localparam int FR = 48000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic [15:0] rate = 16'd0;
    logic        enable = 1'b0;
    logic        req_n;

    int n_tests = 0;
    int n_fail  = 0;
    int macc    = 0;
    bit finished = 0;
    bit rec [0:959];

    always #10 clk = ~clk;

    vrate_pacer dut_i (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .rate(rate), .enable(enable), .req_n(req_n)
    );

    function automatic int clamp_rate(input int r);
        return (r >= FR) ? FR : r;
    endfunction

    // model of R3/R4: returns expected req_n, updates macc
    function automatic bit model_step(input int r, input bit en);
        int s;
        if (!en) begin
            macc = 0;
            return 1'b1;
        end
        s = macc + clamp_rate(r);
        if (s >= FR) begin
            macc = s - FR;
            return 1'b0;
        end
        macc = s;
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one frame: strobe, check request, then gap cycles with hold check (R2)
    task automatic frame(input int gap, input string req, output bit got);
        bit exp;
        bit held;
        exp = model_step(int'(rate), enable);
        @(negedge clk) frame_stb = 1'b1;
        @(negedge clk) frame_stb = 1'b0;
        got = req_n;
        check(req_n == exp, req, req_n, exp);
        held = 1'b1;
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            if (req_n != got) held = 1'b0;
        end
        if (gap > 0) check(held, "R2 hold between strobes", req_n, got);
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit g;
        int cnt;
        bit ok;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(req_n == 1'b1, "R1 reset req_n", req_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_n == 1'b1, "R1 after reset", req_n, 1);

        // R5: full and above-full rates
        enable = 1'b1;
        rate = 16'd48000;
        for (int i = 0; i < 4; i++) frame(2, "R5 rate 48000", g);
        rate = 16'd60000;
        for (int i = 0; i < 4; i++) frame(1, "R5 rate 60000", g);

        // R6: zero rate
        rate = 16'd0;
        for (int i = 0; i < 4; i++) frame(1, "R6 rate 0", g);

        // R3: disable then restart at 44100
        rate = 16'd44100;
        for (int i = 0; i < 5; i++) frame(0, "R4 44100 lead-in", g);
        enable = 1'b0;
        frame(1, "R3 disabled frame", g);
        enable = 1'b1;
        frame(0, "R3 first frame after restart", g);
        check(g == 1'b1, "R3 first not requested", g, 1);
        frame(0, "R3 second frame after restart", g);
        check(g == 1'b0, "R3 second requested", g, 0);

        // R8: enable and rate pulses between strobes are ignored
        for (int i = 0; i < 6; i++) begin
            frame(0, "R8 before glitch", g);
            @(negedge clk) begin enable = 1'b0; rate = 16'd0; end
            @(negedge clk);
            check(req_n == g, "R8 glitch no effect", req_n, g);
            @(negedge clk) begin enable = 1'b1; rate = 16'd44100; end
        end
        frame(0, "R8 after glitches", g);

        // R7: evenness over sliding 480-frame windows
        enable = 1'b0;
        frame(0, "R7 clear", g);
        enable = 1'b1;
        rate = 16'd44100;
        for (int i = 0; i < 960; i++) begin
            frame(0, "R7 44100 frame", g);
            rec[i] = !g;
        end
        ok = 1'b1;
        cnt = 0;
        for (int i = 0; i < 480; i++) cnt += int'(rec[i]);
        if (cnt != 441) ok = 1'b0;
        for (int i = 480; i < 960; i++) begin
            cnt += int'(rec[i]) - int'(rec[i-480]);
            if (cnt != 441) ok = 1'b0;
        end
        check(ok, "R7 441 per 480-window", cnt, 441);
        ok = 1'b1;
        for (int i = 1; i < 960; i++) if (!rec[i] && !rec[i-1]) ok = 1'b0;
        check(ok, "R7 no two consecutive misses", int'(ok), 1);

        // random rates, enables and gaps against the R4 model
        for (int i = 0; i < 300; i++) begin
            case ($urandom_range(0, 5))
                0: rate = 16'd48000;
                1: rate = 16'd8000;
                2: rate = 16'd44100;
                3: rate = 16'($urandom_range(48000, 65535));
                default: rate = 16'($urandom_range(0, 47999));
            endcase
            enable = ($urandom_range(0, 9) != 0);
            frame($urandom_range(0, 5), "R4 random frame", g);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule